// File: doc/BRIEF.md
# Warp Memory Access Coalescer

This block takes one memory request from a 32-lane warp and turns it into a short list of cache-line transactions. Each lane brings an active bit, a byte address and a size code. The block groups every active lane whose address falls in the same 128-byte line into one transaction. It emits these transactions one at a time over a valid/ready output. Each transaction carries the line base address and a mask of the lanes it serves.

The block also reports lanes whose address does not meet the natural alignment of their access size, or whose access runs past the end of its line. It only produces transaction descriptors. Data movement, cache storage and memory bank timing belong to the neighbouring blocks. A new warp request is taken only after the previous one has been fully drained.

Top module: `warp_coalescer`

## Requirements
- R1: After reset, req_ready_o is 1, and txn_valid_o and txn_done_o are 0.
- R2: Each transaction's txn_line_o is the leading lane's byte address with its low 7 bits cleared. Its txn_lanes_o has bit i set exactly for each not-yet-served active lane i in that same 128-byte line.
- R3: When all 32 lanes are active and access consecutive 32-bit words of one aligned line, exactly one transaction is emitted, with txn_lanes_o all ones.
- R4: Lanes in distinct lines cause one transaction per distinct line. The transactions come out in order of the lowest-numbered active lane not yet served.
- R5: Inactive lanes never appear in txn_lanes_o or txn_misalign_o, and their addresses do not affect the transactions.
- R6: Size codes per lane (2 bits) are 0 = 4 bytes, 1 = 8 bytes, 2 = 16 bytes, and 3 is treated as 16 bytes. An active lane is misaligned when its low 2, 3 or 4 address bits (for 4, 8 or 16 bytes) are not all zero. The misalignment mask is presented with the first transaction of a request and is zero on every later one.
- R7: An access whose last byte lies beyond its 128-byte line is flagged misaligned. It is still served only by the transaction of the line holding its start address.
- R8: A request with no active lanes produces no transaction. Instead, txn_done_o is high for exactly one cycle, starting the cycle after acceptance, while txn_valid_o stays 0.
- R9: txn_done_o is high together with the final transaction of a request and low on every earlier transaction.
- R10: While a transaction waits for txn_ready_i, txn_valid_o, txn_line_o and txn_lanes_o hold steady. req_ready_o stays 0 until the last transaction has been taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Warp request valid |
| req_ready_o | output | 1 | Block can accept a warp request |
| req_active_i | input | 32 | Per-lane active bits |
| req_addr_i | input | 1024 | Lane byte addresses, lane i at bits [32i+31:32i] |
| req_size_i | input | 64 | Lane size codes, lane i at bits [2i+1:2i] |
| txn_valid_o | output | 1 | Transaction descriptor valid |
| txn_ready_i | input | 1 | Consumer takes the transaction |
| txn_line_o | output | 32 | Line base byte address |
| txn_lanes_o | output | 32 | Lanes served by this transaction |
| txn_misalign_o | output | 32 | Misaligned lanes of the request (first transaction only) |
| txn_done_o | output | 1 | Final transaction, or empty-request completion pulse |

## Verification
The main function is driven with five address patterns:
- A unit-stride word pattern inside one line, which separates true merging from one-per-lane issue.
- A large-stride pattern that puts each lane in its own line, which exposes any lost or extra transaction.
- An interleaved pattern in which the line of lane 0 sits highest in memory, which distinguishes issue by lowest pending lane from issue by address order.
- A sparse active mask whose inactive lanes point at unrelated lines, which shows whether the active bits gate both the masks and the line choice.
- A mixed-size pattern with offsets just off each boundary, plus a line-crossing access, which separates the three alignment widths and the end-of-line check.

The empty request and a stalled consumer complete the set.

// File: rtl/coal_pkg.sv
package coal_pkg;
  typedef enum logic [1:0] {
    SZ_B4   = 2'd0,
    SZ_B8   = 2'd1,
    SZ_B16  = 2'd2,
    SZ_WIDE = 2'd3
  } size_e;
endpackage

// File: rtl/coal_lane_chk.sv
module coal_lane_chk
  import coal_pkg::*;
#(
  parameter int AW         = 32,
  parameter int LINE_BYTES = 128
) (
  input  logic [AW-1:0] addr_i,
  input  logic [1:0]    size_i,
  output logic          mis_o
);
  localparam int OFF_W = $clog2(LINE_BYTES);

  logic [OFF_W:0]   nbytes;
  logic [OFF_W:0]   span_end;
  logic [OFF_W:0]   lo_mask;

  always_comb begin
    unique case (size_e'(size_i))
      SZ_B4:   nbytes = (OFF_W+1)'(4);
      SZ_B8:   nbytes = (OFF_W+1)'(8);
      default: nbytes = (OFF_W+1)'(16);
    endcase
    lo_mask  = nbytes - (OFF_W+1)'(1);
    span_end = {1'b0, addr_i[OFF_W-1:0]} + nbytes;
    mis_o    = (|(addr_i[OFF_W-1:0] & lo_mask[OFF_W-1:0]))
             || (span_end > (OFF_W+1)'(LINE_BYTES));
  end
endmodule

// File: rtl/coal_lead_pick.sv
module coal_lead_pick #(
  parameter int N  = 32,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  pend_i,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N-1; i >= 0; i--) begin
      if (pend_i[i]) idx_o = IW'(i);
    end
    any_o = |pend_i;
  end
endmodule

// File: rtl/coal_line_match.sv
module coal_line_match #(
  parameter int N  = 32,
  parameter int TW = 25
) (
  input  logic [N-1:0]    pend_i,
  input  logic [N*TW-1:0] tags_i,
  input  logic [TW-1:0]   lead_tag_i,
  output logic [N-1:0]    match_o
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match_o[g] = pend_i[g] && (tags_i[g*TW +: TW] == lead_tag_i);
  end
endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer #(
  parameter int LANES      = 32,
  parameter int AW         = 32,
  parameter int LINE_BYTES = 128
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [LANES-1:0]   req_active_i,
  input  logic [LANES*AW-1:0] req_addr_i,
  input  logic [LANES*2-1:0] req_size_i,
  output logic               txn_valid_o,
  input  logic               txn_ready_i,
  output logic [AW-1:0]      txn_line_o,
  output logic [LANES-1:0]   txn_lanes_o,
  output logic [LANES-1:0]   txn_misalign_o,
  output logic               txn_done_o
);
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int TW    = AW - OFF_W;
  localparam int IW    = $clog2(LANES);

  logic               busy_q, first_q, empty_q;
  logic [LANES-1:0]   pend_q, mis_q;
  logic [LANES*TW-1:0] tags_q;

  logic [LANES-1:0]   mis_raw, match;
  logic [IW-1:0]      lead_idx;
  logic               lead_any;
  logic [TW-1:0]      lead_tag;
  logic               accept, take, last;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    coal_lane_chk #(.AW(AW), .LINE_BYTES(LINE_BYTES)) u_chk (
      .addr_i (req_addr_i[g*AW +: AW]),
      .size_i (req_size_i[g*2 +: 2]),
      .mis_o  (mis_raw[g])
    );
  end

  coal_lead_pick #(.N(LANES), .IW(IW)) u_pick (
    .pend_i (pend_q),
    .idx_o  (lead_idx),
    .any_o  (lead_any)
  );

  assign lead_tag = tags_q[lead_idx*TW +: TW];

  coal_line_match #(.N(LANES), .TW(TW)) u_match (
    .pend_i     (pend_q),
    .tags_i     (tags_q),
    .lead_tag_i (lead_tag),
    .match_o    (match)
  );

  assign req_ready_o    = !busy_q;
  assign accept         = req_valid_i && req_ready_o;
  assign txn_valid_o    = busy_q && lead_any;
  assign take           = txn_valid_o && txn_ready_i;
  assign last           = (pend_q & ~match) == '0;
  assign txn_line_o     = {lead_tag, {OFF_W{1'b0}}};
  assign txn_lanes_o    = txn_valid_o ? match : '0;
  assign txn_misalign_o = (txn_valid_o && first_q) ? mis_q : '0;
  assign txn_done_o     = (txn_valid_o && last) || empty_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      first_q <= 1'b0;
      empty_q <= 1'b0;
      pend_q  <= '0;
      mis_q   <= '0;
      tags_q  <= '0;
    end else begin
      empty_q <= accept && (req_active_i == '0);
      if (accept) begin
        busy_q  <= |req_active_i;
        first_q <= 1'b1;
        pend_q  <= req_active_i;
        mis_q   <= mis_raw & req_active_i;
        for (int i = 0; i < LANES; i++)
          tags_q[i*TW +: TW] <= req_addr_i[i*AW+OFF_W +: TW];
      end else if (take) begin
        pend_q  <= pend_q & ~match;
        first_q <= 1'b0;
        if (last) busy_q <= 1'b0;
      end
    end
  end

  // R10: descriptor held while stalled
  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_valid_o && !txn_ready_i |=> txn_valid_o && $stable(txn_line_o) && $stable(txn_lanes_o));
  // R10: no new request while draining
  a_r10_no_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_valid_o |-> !req_ready_o);
  // R2: a transaction always serves at least one lane
  a_r2_lanes_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_valid_o |-> txn_lanes_o != '0);
  // R6: misalignment mask only on first transaction
  a_r6_mis_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_valid_o && txn_ready_i && !txn_done_o |=> txn_misalign_o == '0);
  // R8: bare done pulse follows an empty request
  a_r8_empty_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_done_o && !txn_valid_o |-> $past(req_valid_i && req_ready_o && req_active_i == '0));
  // R8: empty-request pulse lasts one cycle
  a_r8_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_done_o && !txn_valid_o |=> !(txn_done_o && !txn_valid_o) || $past(req_valid_i && req_ready_o));
endmodule

// File: tb/warp_coalescer_bench.sv
module warp_coalescer_bench;
  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_valid_i = 1'b0;
  logic          req_ready_o;
  logic [31:0]   req_active_i = '0;
  logic [1023:0] req_addr_i = '0;
  logic [63:0]   req_size_i = '0;
  logic          txn_valid_o;
  logic          txn_ready_i = 1'b0;
  logic [31:0]   txn_line_o;
  logic [31:0]   txn_lanes_o;
  logic [31:0]   txn_misalign_o;
  logic          txn_done_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [31:0] act_t;
  logic [31:0] adr_t [32];
  logic [1:0]  sz_t  [32];

  always #5 clk_i = ~clk_i;

  warp_coalescer u_warp_coalescer (
    .clk_i, .rst_ni, .req_valid_i, .req_ready_o, .req_active_i, .req_addr_i,
    .req_size_i, .txn_valid_o, .txn_ready_i, .txn_line_o, .txn_lanes_o,
    .txn_misalign_o, .txn_done_o
  );

  task automatic chk(bit ok, string rq, string what, logic [63:0] got, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, got, exp);
    end
  endtask

  function automatic logic lane_mis(logic [31:0] a, logic [1:0] s);
    int nb = (s == 2'd0) ? 4 : (s == 2'd1) ? 8 : 16;
    return ((a % nb) != 0) || ((a % 128) + nb > 128);
  endfunction

  task automatic clear_req();
    act_t = '0;
    for (int i = 0; i < 32; i++) begin
      adr_t[i] = 32'hDEAD_0000 + 32'(i) * 32'h200;
      sz_t[i]  = 2'd0;
    end
  endtask

  // Drives the current request and checks every transaction against a model.
  task automatic run_req(string rq, bit stall, output int ntx);
    logic [31:0] pend, emis, emask, eline;
    bit first;
    int lead;
    ntx = 0;
    emis = '0;
    for (int i = 0; i < 32; i++)
      if (act_t[i] && lane_mis(adr_t[i], sz_t[i])) emis[i] = 1'b1;
    pend = act_t;
    first = 1;
    @(negedge clk_i);
    chk(req_ready_o == 1'b1, "R10", "ready before request", 64'(req_ready_o), 64'd1);
    req_valid_i  = 1'b1;
    req_active_i = act_t;
    for (int i = 0; i < 32; i++) begin
      req_addr_i[i*32 +: 32] = adr_t[i];
      req_size_i[i*2 +: 2]   = sz_t[i];
    end
    @(posedge clk_i);
    #1 req_valid_i = 1'b0;
    if (pend == '0) begin
      @(negedge clk_i);
      chk(txn_done_o && !txn_valid_o, "R8", "empty done pulse",
          64'({txn_valid_o, txn_done_o}), 64'b01);
      @(negedge clk_i);
      chk(!txn_done_o && !txn_valid_o, "R8", "pulse one cycle",
          64'({txn_valid_o, txn_done_o}), 64'b00);
      return;
    end
    while (pend != '0) begin
      lead = 0;
      for (int i = 31; i >= 0; i--) if (pend[i]) lead = i;
      eline = adr_t[lead] & ~32'h7F;
      emask = '0;
      for (int i = 0; i < 32; i++)
        if (pend[i] && ((adr_t[i] & ~32'h7F) == eline)) emask[i] = 1'b1;
      @(negedge clk_i);
      chk(txn_valid_o == 1'b1, rq, "valid", 64'(txn_valid_o), 64'd1);
      chk(txn_line_o == eline, "R2", "line", 64'(txn_line_o), 64'(eline));
      chk(txn_lanes_o == emask, rq, "lanes", 64'(txn_lanes_o), 64'(emask));
      chk(txn_misalign_o == (first ? emis : 32'h0), "R6", "misalign",
          64'(txn_misalign_o), 64'(first ? emis : 32'h0));
      chk(txn_done_o == ((pend & ~emask) == '0), "R9", "done",
          64'(txn_done_o), 64'((pend & ~emask) == '0));
      chk(req_ready_o == 1'b0, "R10", "ready while busy", 64'(req_ready_o), 64'd0);
      if (stall && first) begin
        @(negedge clk_i);
        chk(txn_valid_o && txn_line_o == eline && txn_lanes_o == emask, "R10",
            "hold under stall", 64'(txn_lanes_o), 64'(emask));
      end
      txn_ready_i = 1'b1;
      @(posedge clk_i);
      #1 txn_ready_i = 1'b0;
      pend &= ~emask;
      first = 0;
      ntx++;
    end
    @(negedge clk_i);
    chk(!txn_valid_o && req_ready_o, "R10", "idle after drain",
        64'({txn_valid_o, req_ready_o}), 64'b01);
  endtask

  task automatic t_reset();
    @(negedge clk_i);
    chk(req_ready_o && !txn_valid_o && !txn_done_o, "R1", "reset state",
        64'({req_ready_o, txn_valid_o, txn_done_o}), 64'b100);
  endtask

  task automatic t_unit_stride();
    int n;
    clear_req();
    act_t = '1;
    for (int i = 0; i < 32; i++) adr_t[i] = 32'h0000_1000 + 32'(i) * 4;
    run_req("R3", 0, n);
    chk(n == 1, "R3", "txn count", 64'(n), 64'd1);
  endtask

  task automatic t_far_stride();
    int n;
    clear_req();
    act_t = '1;
    for (int i = 0; i < 32; i++) adr_t[i] = 32'h0010_0000 + 32'(i) * 32'h1000;
    run_req("R4", 1, n);
    chk(n == 32, "R4", "txn count", 64'(n), 64'd32);
  endtask

  task automatic t_interleave();
    int n;
    clear_req();
    act_t = '1;
    for (int i = 0; i < 32; i++)
      adr_t[i] = 32'h0000_3000 + 32'(3 - (i % 4)) * 128 + 32'(i / 4) * 4;
    run_req("R4", 0, n);
    chk(n == 4, "R4", "interleave count", 64'(n), 64'd4);
  endtask

  task automatic t_sparse();
    int n;
    clear_req();
    act_t = 32'hA5A5_0F0F;
    for (int i = 0; i < 32; i++)
      adr_t[i] = act_t[i] ? 32'h0000_5000 + 32'(i % 2) * 128 + 32'(i) * 2
                          : 32'h0077_0000 + 32'(i) * 32'h100;
    for (int i = 0; i < 32; i++) if (!act_t[i]) sz_t[i] = 2'd1;
    run_req("R5", 0, n);
    chk(n == 2, "R5", "sparse count", 64'(n), 64'd2);
  endtask

  task automatic t_misalign();
    int n;
    clear_req();
    act_t = 32'h0000_00FF;
    adr_t[0] = 32'h0000_8000; sz_t[0] = 2'd0;
    adr_t[1] = 32'h0000_8004; sz_t[1] = 2'd1;
    adr_t[2] = 32'h0000_8008; sz_t[2] = 2'd2;
    adr_t[3] = 32'h0000_807E; sz_t[3] = 2'd0;
    adr_t[4] = 32'h0000_8078; sz_t[4] = 2'd2;
    adr_t[5] = 32'h0000_8088; sz_t[5] = 2'd1;
    adr_t[6] = 32'h0000_8098; sz_t[6] = 2'd3;
    adr_t[7] = 32'h0000_80F0; sz_t[7] = 2'd2;
    run_req("R6", 1, n);
    chk(n == 2, "R7", "crossing adds no txn", 64'(n), 64'd2);
  endtask

  task automatic t_cross_only();
    int n;
    clear_req();
    act_t = 32'h0000_0001;
    adr_t[0] = 32'h0000_907C; sz_t[0] = 2'd1;
    run_req("R7", 0, n);
    chk(n == 1, "R7", "single line", 64'(n), 64'd1);
  endtask

  task automatic t_empty();
    int n;
    clear_req();
    run_req("R8", 0, n);
    chk(n == 0, "R8", "no txn", 64'(n), 64'd0);
  endtask

  initial begin
    clear_req();
    #12 rst_ni = 1'b1;
    t_reset();
    t_unit_stride();
    t_far_stride();
    t_interleave();
    t_sparse();
    t_misalign();
    t_cross_only();
    t_empty();
    t_unit_stride();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule